// File: doc/BRIEF.md
# Operate/Suspend Dual-Latch Power Switch Controller

This block controls the switch network of one power channel. Each committed command byte lands in one of two latches, chosen by the top bit of the byte. An operate latch takes effect on the outputs straight away. A suspend latch holds a standby command that is applied only while an active-low suspend input is held low. When that input returns high, the outputs go back to the operate-latch contents.

The block decodes the latch in use into two one-hot switch selections and a fault-interrupt mask. The main rail output is one of ground, source X, source Y or high impedance. The programming rail output is one of ground, the main rail, the 12 V input or high impedance. For each rail, a high-impedance bit wins over the matching on bit. The decoded outputs are registered, so they never glitch while a latch is being rewritten.

Timing is as follows. A commit strobe at clock edge N writes a latch at edge N, and the outputs reflect that latch after edge N+1. A change on the suspend input that is sampled at edge N shows on the outputs after edge N.

Top module: `sw_chan_ctrl`

## Requirements
- R1: After reset, both latches hold 0x00. `main_sel` is 4'b0001 (ground), `prog_sel` is 4'b0001 (ground) and `fault_mask` is 0.
- R2: A commit with bit 7 = 1 writes the byte into the operate latch. While `susp_n` is high, the outputs show the decoded byte two clocks after the commit strobe.
- R3: A commit with bit 7 = 0 writes the byte into the suspend latch only. While `susp_n` is high, the outputs do not change.
- R4: While `susp_n` is low, the outputs show the decoded suspend latch, one clock after `susp_n` is sampled low.
- R5: When `susp_n` returns high, the outputs show the decoded operate latch again, one clock later.
- R6: While `susp_n` is low, a suspend-latch write changes the outputs two clocks after the strobe, and an operate-latch write leaves the outputs unchanged.
- R7: `main_sel` uses the one-hot code [0]=ground, [1]=source X, [2]=source Y, [3]=high-Z. Bit 4 = 1 gives high-Z whatever bit 6 holds. Otherwise bit 6 = 0 gives ground, and bit 6 = 1 gives source Y when bit 5 = 1 or source X when bit 5 = 0.
- R8: `prog_sel` uses the one-hot code [0]=ground, [1]=main rail, [2]=12 V input, [3]=high-Z. Bit 1 = 1 gives high-Z whatever bit 3 holds. Otherwise bit 3 = 0 gives ground, and bit 3 = 1 gives 12 V when bit 2 = 1 or the main rail when bit 2 = 0.
- R9: `fault_mask` equals bit 0 of the latch in use, with the same latency as the switch outputs.
- R10: `main_sel` and `prog_sel` each have exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Commit strobe for `cmd_byte` |
| cmd_byte | input | 8 | Command byte; bit 7 selects the latch |
| susp_n | input | 1 | Active-low suspend request (synchronous) |
| main_sel | output | 4 | One-hot main rail selection |
| prog_sel | output | 4 | One-hot programming rail selection |
| fault_mask | output | 1 | Masks fault interrupts for both channels |

## Verification
The hardest state to reach is a suspend period in which both latches are rewritten. To get there, the bench first loads distinct operate and suspend commands and then pulls `susp_n` low. While suspended, it commits a new operate byte and checks that the outputs do not move. It then commits a new suspend byte and checks that the outputs follow it. Finally it releases `susp_n` and checks that the outputs return to the operate byte written during the suspension.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int CMD_W      = 8;
    localparam int SEL_W      = 4;
    // command bit positions (decoded by this block)
    localparam int B_LATCH    = 7;
    localparam int B_MAIN_ON  = 6;
    localparam int B_MAIN_Y   = 5;
    localparam int B_MAIN_HZ  = 4;
    localparam int B_PROG_ON  = 3;
    localparam int B_PROG_12V = 2;
    localparam int B_PROG_HZ  = 1;
    localparam int B_MASK     = 0;
    // one-hot selection codes
    localparam logic [SEL_W-1:0] M_GND  = 4'b0001;
    localparam logic [SEL_W-1:0] M_SRCX = 4'b0010;
    localparam logic [SEL_W-1:0] M_SRCY = 4'b0100;
    localparam logic [SEL_W-1:0] M_HIZ  = 4'b1000;
    localparam logic [SEL_W-1:0] P_GND  = 4'b0001;
    localparam logic [SEL_W-1:0] P_MAIN = 4'b0010;
    localparam logic [SEL_W-1:0] P_12V  = 4'b0100;
    localparam logic [SEL_W-1:0] P_HIZ  = 4'b1000;

    typedef struct packed {
        logic [CMD_W-1:0] op;
        logic [CMD_W-1:0] sus;
    } latch_t;

    typedef struct packed {
        logic [SEL_W-1:0] main_sel;
        logic [SEL_W-1:0] prog_sel;
        logic             mask;
    } rail_t;
endpackage

// File: rtl/sw_cmd_latches.sv
module sw_cmd_latches
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             susp_n,
    output logic [CMD_W-1:0] active_cmd
);
    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (cmd_valid) begin
            if (cmd_byte[B_LATCH]) lat_d.op  = cmd_byte;
            else                   lat_d.sus = cmd_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign active_cmd = susp_n ? lat_q.op : lat_q.sus;

    AST_OP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[B_LATCH]) |=> (lat_q.op == $past(cmd_byte))) else $error("op load"); // R2
    AST_SUS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[B_LATCH]) |=> $stable(lat_q.sus)) else $error("sus touched"); // R2
    AST_OP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_byte[B_LATCH]) |=> $stable(lat_q.op)) else $error("op touched"); // R3
endmodule

// File: rtl/sw_rail_decode.sv
module sw_rail_decode
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] active_cmd,
    output rail_t            rail
);
    rail_t rail_d, rail_q;

    always_comb begin
        rail_d = rail_q;
        // main rail: high-Z wins over on
        if (active_cmd[B_MAIN_HZ])       rail_d.main_sel = M_HIZ;
        else if (!active_cmd[B_MAIN_ON]) rail_d.main_sel = M_GND;
        else if (active_cmd[B_MAIN_Y])   rail_d.main_sel = M_SRCY;
        else                             rail_d.main_sel = M_SRCX;
        // programming rail: high-Z wins over on
        if (active_cmd[B_PROG_HZ])       rail_d.prog_sel = P_HIZ;
        else if (!active_cmd[B_PROG_ON]) rail_d.prog_sel = P_GND;
        else if (active_cmd[B_PROG_12V]) rail_d.prog_sel = P_12V;
        else                             rail_d.prog_sel = P_MAIN;
        rail_d.mask = active_cmd[B_MASK];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_q.main_sel <= M_GND;
            rail_q.prog_sel <= P_GND;
            rail_q.mask     <= 1'b0;
        end else begin
            rail_q <= rail_d;
        end
    end

    assign rail = rail_q;

    AST_MAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_q.main_sel) == 1) else $error("main not one-hot"); // R10
    AST_PROG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_q.prog_sel) == 1) else $error("prog not one-hot"); // R10
    AST_MAIN_HIZ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        active_cmd[B_MAIN_HZ] |=> rail_q.main_sel[3]) else $error("main hiz"); // R7
    AST_PROG_HIZ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        active_cmd[B_PROG_HZ] |=> rail_q.prog_sel[3]) else $error("prog hiz"); // R8
    AST_MASK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rail_q.mask == $past(active_cmd[B_MASK]))) else $error("mask"); // R9
endmodule

// File: rtl/sw_chan_ctrl.sv
module sw_chan_ctrl
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             susp_n,
    output logic [3:0]       main_sel,
    output logic [3:0]       prog_sel,
    output logic             fault_mask
);
    logic [CMD_W-1:0] active_cmd;
    rail_t            rail;

    sw_cmd_latches i_latches (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .susp_n     (susp_n),
        .active_cmd (active_cmd)
    );

    sw_rail_decode i_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_cmd (active_cmd),
        .rail       (rail)
    );

    assign main_sel   = rail.main_sel;
    assign prog_sel   = rail.prog_sel;
    assign fault_mask = rail.mask;

    AST_RESET_GND: assert property (@(posedge clk)
        $rose(rst_n) |-> (main_sel == M_GND && prog_sel == P_GND && !fault_mask)) else $error("reset state"); // R1
endmodule

// File: tb/test_sw_chan_ctrl.sv
module test_sw_chan_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       susp_n = 1'b1;
    logic [3:0] main_sel, prog_sel;
    logic       fault_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_chan_ctrl i_sw_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .susp_n(susp_n), .main_sel(main_sel), .prog_sel(prog_sel), .fault_mask(fault_mask)
    );

    function automatic logic [3:0] exp_main(input logic [7:0] b);
        if (b[4])      return 4'b1000;
        else if (!b[6]) return 4'b0001;
        else if (b[5]) return 4'b0100;
        else           return 4'b0010;
    endfunction

    function automatic logic [3:0] exp_prog(input logic [7:0] b);
        if (b[1])      return 4'b1000;
        else if (!b[3]) return 4'b0001;
        else if (b[2]) return 4'b0100;
        else           return 4'b0010;
    endfunction

    task automatic check_outs(input string req, input logic [7:0] b);
        checks++;
        if (main_sel !== exp_main(b) || prog_sel !== exp_prog(b) || fault_mask !== b[0]) begin
            fails++;
            $display("FAIL %s: main=%b prog=%b mask=%b expected main=%b prog=%b mask=%b",
                     req, main_sel, prog_sel, fault_mask, exp_main(b), exp_prog(b), b[0]);
        end
        checks++;
        if ($countones(main_sel) != 1 || $countones(prog_sel) != 1) begin
            fails++;
            $display("FAIL R10: main=%b prog=%b expected one-hot each", main_sel, prog_sel);
        end
    endtask

    // strobe at one edge; returns at the negedge after the outputs update
    task automatic commit(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_susp(input logic v);
        @(negedge clk); susp_n = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check_outs("R1", 8'h00);
    endtask

    task automatic t_operate;
        commit(8'hC8); check_outs("R2", 8'hC8);   // main X, prog main
        commit(8'hEC); check_outs("R7", 8'hEC);   // main Y, prog 12V
        commit(8'hE4); check_outs("R8", 8'hE4);   // prog off: 12V bit ignored
    endtask

    task automatic t_hiz;
        commit(8'hDA); check_outs("R7", 8'hDA);   // both high-Z with on bits set
        commit(8'h90); check_outs("R7", 8'h90);   // main high-Z, on bit clear
        commit(8'h8E); check_outs("R8", 8'h8E);   // prog high-Z overrides on+12V
    endtask

    task automatic t_mask;
        commit(8'h81); check_outs("R9", 8'h81);
    endtask

    task automatic t_suspend;
        commit(8'h6D);                      // into suspend latch
        @(negedge clk);
        check_outs("R3", 8'h81);            // operate contents still shown
        set_susp(1'b0); check_outs("R4", 8'h6D);
        commit(8'hC8);  @(negedge clk);
        check_outs("R6", 8'h6D);            // operate write hidden while suspended
        commit(8'h50);  check_outs("R6", 8'h50);
        commit(8'h03);  check_outs("R9", 8'h03);
        set_susp(1'b1); check_outs("R5", 8'hC8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_operate();
        t_hiz();
        t_mask();
        t_suspend();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule